// File: doc/BRIEF.md
# Predicated Vector Compare Unit

The unit executes one lane-wise integer comparison between two 128-bit vector operands and writes the outcome into a 32-bit predicate register that it holds. The predicate has one bit per operand byte. When lanes are wider than a byte, each lane's result is copied into every predicate bit that covers that lane's bytes. The operands are split into sixteen byte lanes, eight halfword lanes or four word lanes, and eight conditions are offered: equality, inequality, unsigned greater-or-equal, unsigned greater-than, and four signed orderings.

The unit decodes the 32-bit compare instruction word itself. It drives the two register indices out to an external register file, which returns the operands on the same cycle. Two byte-indexed masks decide how the result is merged. A byte whose beat is not executed keeps its old predicate bit. A byte in an executed beat whose lane is disabled gets a 0. Every other byte takes the comparison result. When the instruction carries a nonzero 4-bit block mask, the same update also writes that mask into both mask fields of the predicate register, which starts a predicated block. A malformed word raises `illegal` and leaves the register untouched.

Top module: `vcmp_unit`

## Requirements
- R1: Size field insn[21:20] = 0, 1 or 2 splits the operands into 16 byte, 8 halfword or 4 word lanes. Lane k occupies the k-th element counting up from bit 0, and predicate bit i belongs to operand byte i (bits 8i+7:8i).
- R2: Each lane's result is written into all 1, 2 or 4 predicate bits that cover that lane's bytes.
- R3: The condition code is {insn[12], insn[0], insn[7]}, with 0=EQ, 1=NE, 2=unsigned >=, 3=unsigned >, 4=signed >=, 5=signed <, 6=signed >, 7=signed <=. The comparison is always first operand versus second operand.
- R4: In an executed beat (beat_exec[i]=1) with lane_en[i]=0, predicate bit i becomes 0.
- R5: Where beat_exec[i]=0, predicate bit i keeps its previous value.
- R6: A compare whose block mask is zero leaves predicate bits 31:16 unchanged.
- R7: The block mask is {insn[22], insn[15:13]}. When it is nonzero, the same update writes it into predicate bits 19:16 and 23:20. Bits 31:24 never change.
- R8: `illegal` = issue and (size 3, or insn[5]=1, or any fixed bit differs: insn[31:23]=111111100, insn[16]=1, insn[11:8]=1111, insn[6]=0, insn[4]=0). An illegal issue leaves the whole predicate unchanged.
- R9: Reset clears the predicate to zero. A cycle without issue leaves it unchanged.
- R10: src_n_idx = insn[19:17] and src_m_idx = {insn[5], insn[3:1]}, both combinational.
- R11: The predicate update becomes visible after the rising clock edge at which `issue` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Instruction presented this cycle |
| insn | input | 32 | Compare instruction word |
| opnd_n | input | 128 | First operand, read from register src_n_idx |
| opnd_m | input | 128 | Second operand, read from register src_m_idx |
| lane_en | input | 16 | Per-byte lane enable |
| beat_exec | input | 16 | Per-byte beat-execute mask |
| src_n_idx | output | 3 | First operand register index |
| src_m_idx | output | 4 | Second operand register index |
| illegal | output | 1 | Issued word is not a valid compare |
| pred_q | output | 32 | Predicate register |

## Verification
The assertions assume that `issue`, `insn` and both masks are defined from the first clock after reset, and that the operands belong to the word presented in the same cycle. The bench holds all inputs at known values from time zero. It changes them only on falling edges, so every rising edge samples one complete instruction and its data. Random traffic mixes legal and deliberately malformed words, all built from the documented field positions.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;

    typedef enum logic [2:0] {
        C_EQ  = 3'd0,
        C_NE  = 3'd1,
        C_UGE = 3'd2,
        C_UGT = 3'd3,
        C_SGE = 3'd4,
        C_SLT = 3'd5,
        C_SGT = 3'd6,
        C_SLE = 3'd7
    } cond_e;

    typedef struct packed {
        cond_e      cond;
        logic [1:0] size;
        logic [2:0] n_idx;
        logic [3:0] m_idx;
        logic [3:0] mask;
        logic       bad;
    } dec_t;

    // Fold the three primitive relations into the selected condition.
    function automatic logic eval_cond(cond_e c, logic eq, logic ult, logic slt);
        logic r;
        unique case (c)
            C_EQ:    r = eq;
            C_NE:    r = !eq;
            C_UGE:   r = !ult;
            C_UGT:   r = !ult && !eq;
            C_SGE:   r = !slt;
            C_SLT:   r = slt;
            C_SGT:   r = !slt && !eq;
            default: r = slt || eq;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/vcmp_decode.sv
module vcmp_decode
    import vcmp_pkg::*;
(
    input  logic [31:0] insn,
    output dec_t        dec
);
    localparam logic [8:0] TOP_OPC = 9'b111111100;

    logic fixed_ok;

    always_comb begin
        fixed_ok = (insn[31:23] == TOP_OPC) && insn[16] && (insn[11:8] == 4'hF)
                   && !insn[6] && !insn[4];
        dec.cond  = cond_e'({insn[12], insn[0], insn[7]});
        dec.size  = insn[21:20];
        dec.n_idx = insn[19:17];
        dec.m_idx = {insn[5], insn[3:1]};
        dec.mask  = {insn[22], insn[15:13]};
        dec.bad   = !fixed_ok || (insn[21:20] == 2'd3) || insn[5];
    end
endmodule

// File: rtl/vcmp_lanes.sv
module vcmp_lanes
    import vcmp_pkg::*;
#(
    parameter int VEC_BYTES = 16
) (
    input  logic [VEC_BYTES*8-1:0] a,
    input  logic [VEC_BYTES*8-1:0] b,
    input  cond_e                  cond,
    input  logic [1:0]             size,
    output logic [VEC_BYTES-1:0]   hit
);
    localparam int NUM_SIZES = 3;

    logic [NUM_SIZES-1:0][VEC_BYTES-1:0] res;

    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_sz
        localparam int EB = 1 << s;
        localparam int EW = 8 * EB;
        localparam int NL = VEC_BYTES / EB;
        for (genvar l = 0; l < NL; l++) begin : g_ln
            logic [EW-1:0] xa, xb;
            logic          eq, ult, slt;
            assign xa  = a[l*EW +: EW];
            assign xb  = b[l*EW +: EW];
            assign eq  = (xa == xb);
            assign ult = (xa < xb);
            assign slt = ($signed(xa) < $signed(xb));
            assign res[s][l*EB +: EB] = {EB{eval_cond(cond, eq, ult, slt)}};
        end
    end

    always_comb begin
        unique case (size)
            2'd0:    hit = res[0];
            2'd1:    hit = res[1];
            2'd2:    hit = res[2];
            default: hit = '0;
        endcase
    end
endmodule

// File: rtl/vcmp_predreg.sv
module vcmp_predreg #(
    parameter int PRED_W      = 32,
    parameter int LANES       = 16,
    parameter int MASK_W      = 4,
    parameter int MASK_LSB    = 16,
    parameter int MASK_FIELDS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [LANES-1:0]  hit,
    input  logic [LANES-1:0]  lane_en,
    input  logic [LANES-1:0]  beat_exec,
    input  logic [MASK_W-1:0] mask_in,
    output logic [PRED_W-1:0] pred_q
);
    logic [PRED_W-1:0] pred_d;

    always_comb begin
        pred_d = pred_q;
        if (wr_en) begin
            for (int i = 0; i < LANES; i++) begin
                if (beat_exec[i]) pred_d[i] = hit[i] & lane_en[i];
            end
            if (|mask_in) begin
                for (int f = 0; f < MASK_FIELDS; f++) begin
                    pred_d[MASK_LSB + f*MASK_W +: MASK_W] = mask_in;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pred_q <= '0;
        else        pred_q <= pred_d;
    end
endmodule

// File: rtl/vcmp_unit.sv
module vcmp_unit
    import vcmp_pkg::*;
#(
    parameter int VEC_BYTES   = 16,
    parameter int PRED_W      = 32,
    parameter int MASK_W      = 4,
    parameter int MASK_LSB    = 16,
    parameter int MASK_FIELDS = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   issue,
    input  logic [31:0]            insn,
    input  logic [VEC_BYTES*8-1:0] opnd_n,
    input  logic [VEC_BYTES*8-1:0] opnd_m,
    input  logic [VEC_BYTES-1:0]   lane_en,
    input  logic [VEC_BYTES-1:0]   beat_exec,
    output logic [2:0]             src_n_idx,
    output logic [3:0]             src_m_idx,
    output logic                   illegal,
    output logic [PRED_W-1:0]      pred_q
);
    dec_t                 dec;
    logic [VEC_BYTES-1:0] hit;
    logic                 wr_en;

    vcmp_decode u_dec (
        .insn (insn),
        .dec  (dec)
    );

    vcmp_lanes #(.VEC_BYTES(VEC_BYTES)) u_lanes (
        .a    (opnd_n),
        .b    (opnd_m),
        .cond (dec.cond),
        .size (dec.size),
        .hit  (hit)
    );

    assign wr_en     = issue && !dec.bad;
    assign illegal   = issue && dec.bad;
    assign src_n_idx = dec.n_idx;
    assign src_m_idx = dec.m_idx;

    vcmp_predreg #(
        .PRED_W      (PRED_W),
        .LANES       (VEC_BYTES),
        .MASK_W      (MASK_W),
        .MASK_LSB    (MASK_LSB),
        .MASK_FIELDS (MASK_FIELDS)
    ) u_pred (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .hit       (hit),
        .lane_en   (lane_en),
        .beat_exec (beat_exec),
        .mask_in   (dec.mask),
        .pred_q    (pred_q)
    );
endmodule

// File: rtl/vcmp_unit_chk.sv
module vcmp_unit_chk #(
    parameter int VEC_BYTES   = 16,
    parameter int PRED_W      = 32,
    parameter int MASK_W      = 4,
    parameter int MASK_LSB    = 16,
    parameter int MASK_FIELDS = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 issue,
    input logic [31:0]          insn,
    input logic [VEC_BYTES-1:0] lane_en,
    input logic [VEC_BYTES-1:0] beat_exec,
    input logic [2:0]           src_n_idx,
    input logic [3:0]           src_m_idx,
    input logic                 illegal,
    input logic [PRED_W-1:0]    pred_q
);
    localparam int TOP_LSB = MASK_LSB + MASK_FIELDS * MASK_W;

    logic [MASK_W-1:0] blk_mask;
    assign blk_mask = {insn[22], insn[15:13]};

    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> $stable(pred_q));

    assert_illegal_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> $stable(pred_q));

    assert_size3_illegal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && insn[21:20] == 2'd3) |-> illegal);

    assert_beat_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pred_q[VEC_BYTES-1:0] & ~$past(beat_exec)) ==
                  ($past(pred_q[VEC_BYTES-1:0]) & ~$past(beat_exec))));

    assert_lane_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !illegal) |=> ((pred_q[VEC_BYTES-1:0] & $past(beat_exec & ~lane_en)) == '0));

    assert_mask_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_mask == '0) |=> $stable(pred_q[PRED_W-1:VEC_BYTES]));

    assert_mask_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !illegal && blk_mask != '0) |=>
            (pred_q[MASK_LSB +: MASK_W] == $past(blk_mask)));

    assert_upper_const_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(pred_q[PRED_W-1:TOP_LSB]));

    assert_idx_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (src_m_idx == {insn[5], insn[3:1]}) && (src_n_idx == insn[19:17]));
endmodule

bind vcmp_unit vcmp_unit_chk #(
    .VEC_BYTES(VEC_BYTES), .PRED_W(PRED_W), .MASK_W(MASK_W),
    .MASK_LSB(MASK_LSB), .MASK_FIELDS(MASK_FIELDS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .issue(issue), .insn(insn), .lane_en(lane_en),
    .beat_exec(beat_exec), .src_n_idx(src_n_idx), .src_m_idx(src_m_idx),
    .illegal(illegal), .pred_q(pred_q)
);

// File: tb/tb_vcmp_unit.sv
module tb_vcmp_unit;
    logic         clk = 0;
    logic         rst_n = 0;
    logic         issue = 0;
    logic [31:0]  insn = '0;
    logic [127:0] opnd_n = '0, opnd_m = '0;
    logic [15:0]  lane_en = '0, beat_exec = '0;
    logic [2:0]   src_n_idx;
    logic [3:0]   src_m_idx;
    logic         illegal;
    logic [31:0]  pred_q;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [31:0] exp_pred;

    always #4 clk = ~clk;

    vcmp_unit dut (.*);

    function automatic logic [31:0] mk(input int cond, input int size, input int n,
                                       input int m, input int mask);
        logic [31:0] w = '0;
        w[31:23] = 9'b111111100; w[22] = mask[3]; w[21:20] = size[1:0];
        w[19:17] = n[2:0]; w[16] = 1'b1; w[15:13] = mask[2:0]; w[12] = cond[2];
        w[11:8] = 4'hF; w[7] = cond[0]; w[5] = m[3]; w[3:1] = m[2:0]; w[0] = cond[1];
        return w;
    endfunction

    function automatic logic is_bad(input logic [31:0] w);
        return !(w[31:23] == 9'b111111100 && w[16] && w[11:8] == 4'hF && !w[6] && !w[4])
               || w[21:20] == 2'd3 || w[5];
    endfunction

    function automatic logic [15:0] ref_hits(input logic [31:0] w, input logic [127:0] a,
                                             input logic [127:0] b);
        logic [15:0] r = '0;
        int cond = {w[12], w[0], w[7]};
        int eb = 1 << w[21:20];
        int bits = eb * 8;
        for (int e = 0; e < 16 / eb; e++) begin
            logic [127:0] sa_v = a >> (e * bits);
            logic [127:0] sb_v = b >> (e * bits);
            longint ua = longint'(sa_v[31:0]) & ((64'sd1 <<< bits) - 1);
            longint ub = longint'(sb_v[31:0]) & ((64'sd1 <<< bits) - 1);
            longint sa = (ua <<< (64 - bits)) >>> (64 - bits);
            longint sb = (ub <<< (64 - bits)) >>> (64 - bits);
            logic h;
            case (cond)
                0: h = (ua == ub);
                1: h = (ua != ub);
                2: h = (ua >= ub);
                3: h = (ua > ub);
                4: h = (sa >= sb);
                5: h = (sa < sb);
                6: h = (sa > sb);
                default: h = (sa <= sb);
            endcase
            for (int k = 0; k < eb; k++) r[e*eb + k] = h;
        end
        return r;
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, check illegal and indices at once,
    // then check the predicate after the following rising edge.
    task automatic op(input logic do_issue, input logic [31:0] w, input logic [127:0] a,
                      input logic [127:0] b, input logic [15:0] le, input logic [15:0] be,
                      input string req);
        logic [15:0] h;
        logic        bad;
        logic [3:0]  mk4;
        issue = do_issue; insn = w; opnd_n = a; opnd_m = b; lane_en = le; beat_exec = be;
        #1;
        bad = is_bad(w);
        check({31'd0, illegal}, {31'd0, do_issue && bad}, {"R8 illegal ", req});
        check({25'd0, src_n_idx, src_m_idx}, {25'd0, w[19:17], w[5], w[3:1]}, "R10 indices");
        if (do_issue && !bad) begin
            h = ref_hits(w, a, b);
            for (int i = 0; i < 16; i++)
                if (be[i]) exp_pred[i] = h[i] & le[i];
            mk4 = {w[22], w[15:13]};
            if (mk4 != 0) begin
                exp_pred[19:16] = mk4;
                exp_pred[23:20] = mk4;
            end
        end
        @(posedge clk);
        @(negedge clk);
        check(pred_q, exp_pred, {"R11 predicate ", req});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [127:0] a, b;
        exp_pred = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        check(pred_q, 32'd0, "R9 reset state");

        // R1 byte lanes equality, distinct bytes
        a = 128'h00112233_44556677_8899AABB_CCDDEEFF;
        b = 128'h00FF2233_44006677_8899AA00_CCDDEE00;
        op(1, mk(0, 0, 1, 2, 0), a, b, 16'hFFFF, 16'hFFFF, "R1 R3 bytes EQ");
        // R2 halfword replication, NE
        op(1, mk(1, 1, 0, 3, 0), a, b, 16'hFFFF, 16'hFFFF, "R2 halfword NE");
        // R2 word replication, EQ
        op(1, mk(0, 2, 0, 3, 0), a, b, 16'hFFFF, 16'hFFFF, "R2 word EQ");
        // R3 signed vs unsigned boundary: 0x80 vs 0x7F
        a = {16{8'h80}}; b = {16{8'h7F}};
        op(1, mk(3, 0, 0, 0, 0), a, b, 16'hFFFF, 16'hFFFF, "R3 unsigned GT all set");
        op(1, mk(6, 0, 0, 0, 0), a, b, 16'hFFFF, 16'hFFFF, "R3 signed GT all clear");
        op(1, mk(5, 0, 0, 0, 0), a, b, 16'hFFFF, 16'hFFFF, "R3 signed LT");
        op(1, mk(2, 2, 0, 0, 0), a, a, 16'hFFFF, 16'hFFFF, "R3 unsigned GE equal");
        op(1, mk(7, 1, 0, 0, 0), b, a, 16'hFFFF, 16'hFFFF, "R3 signed LE");
        // R4 lane disable in executed beats
        op(1, mk(0, 0, 0, 0, 0), a, a, 16'h0F0F, 16'hFFFF, "R4 lane disable");
        // R5 beat not executed keeps old bits
        op(1, mk(1, 0, 0, 0, 0), a, a, 16'hFFFF, 16'h00FF, "R5 beat keep");
        op(1, mk(0, 0, 0, 0, 0), a, a, 16'h00F0, 16'hF0F0, "R4 R5 mixed");
        // R7 mask load, then R6 plain compare keeps it
        op(1, mk(0, 1, 0, 0, 4'b1010), a, b, 16'hFFFF, 16'hFFFF, "R7 mask load");
        op(1, mk(0, 0, 0, 0, 0), a, a, 16'hFFFF, 16'hFFFF, "R6 mask kept");
        op(1, mk(4, 2, 0, 0, 4'b0001), a, b, 16'hFFFF, 16'hFFFF, "R7 mask reload");
        // R8 illegal words leave predicate alone
        op(1, mk(0, 3, 0, 0, 4'b1111), a, a, 16'hFFFF, 16'hFFFF, "R8 size 3");
        op(1, mk(1, 0, 0, 9, 4'b1111), a, b, 16'hFFFF, 16'hFFFF, "R8 bit5 set");
        op(1, mk(1, 0, 0, 0, 4'b1111) ^ 32'h0000_0010, a, b, 16'hFFFF, 16'hFFFF, "R8 bit4 set");
        op(1, mk(1, 0, 0, 0, 0) ^ 32'h0001_0000, a, b, 16'hFFFF, 16'hFFFF, "R8 opcode bit16");
        // R9 no issue holds
        op(0, mk(1, 0, 0, 0, 4'b0110), a, b, 16'hFFFF, 16'hFFFF, "R9 idle hold");

        // Random mix, including malformed words
        for (int t = 0; t < 300; t++) begin
            logic [31:0] w;
            a = {$urandom, $urandom, $urandom, $urandom};
            b = (t % 3 == 0) ? a ^ (128'(1) << ($urandom % 128)) : {$urandom, $urandom, $urandom, $urandom};
            w = mk($urandom % 8, $urandom % 3, $urandom % 8, $urandom % 8,
                   ($urandom % 4 == 0) ? ($urandom % 16) : 0);
            if ($urandom % 8 == 0) w = w ^ (32'd1 << ($urandom % 32));
            op(($urandom % 8) != 0, w, a, b, 16'($urandom), 16'($urandom), "R1 R2 R3 random");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule